// File: doc/BRIEF.md
# Ethernet PHY Low-Power Mode Controller

This block decides which power domains of an Ethernet PHY stay alive. A management write loads three settings: a power-saving enable, a two-bit mode select and a clock-stop request. The block turns these into separate enables for the management logic, the energy detector, the transmit/receive datapath and the internal clocks. The analog energy detector and the pulse generator sit outside the block. The block sees only a "link partner present" input and drives a one-cycle request for a normal link pulse (NLP).

There are four modes. The block only acts on the mode select while the enable is set; otherwise the PHY runs at full power. In the IEEE-style power-down mode only the management logic stays up, and the internal clocks can be stopped. In the two sleep modes the energy detector also stays up. The active sleep mode also requests an NLP about every 1.4 s; a prescaled counter sets the interval, and simulation can shorten it. When a sleep mode sees a link partner, it returns to full power without any software write and leaves a sticky wake flag behind.

Top module: `phy_pwr_ctrl`

## Requirements
- R1: After reset the enable, the mode field (0), the clock-stop request and the wake flag all read 0. All domain enables and the clock enable are 1, and no NLP request is raised.
- R2: While the enable reads 0, every domain and the clock stay on and no NLP is requested, whatever the mode and clock-stop settings hold.
- R3: With the enable set and mode 1 (IEEE power down), only the management logic is powered. The energy detector and datapath enables are 0.
- R4: The clock enable is the inverse of the clock-stop request only in IEEE power down. In every other effective mode the clock enable is 1.
- R5: With the enable set and mode 2 (active sleep) or mode 3 (passive sleep), the management and energy detector enables are 1, the datapath enable is 0 and the clock enable is 1.
- R6: In active sleep the NLP request is a single-cycle pulse. It first rises PRE_DIV*NLP_TICKS-1 cycles after the cycle in which the mode took effect, and then repeats every PRE_DIV*NLP_TICKS cycles. It never rises in passive sleep or any other mode.
- R7: In either sleep mode, link_energy high at a clock edge with no write in the same cycle clears the mode to 0, keeps the enable set and sets the wake flag. Full power is restored in the next cycle.
- R8: The wake flag stays set until any management write clears it. link_energy has no effect in normal mode or IEEE power down.
- R9: When the block leaves IEEE power down for normal mode, the clock enable returns in the first cycle and the datapath enable one cycle later.
- R10: A management write in the same cycle as a wake event takes priority. The written mode is kept and the wake flag ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mgmt_we | input | 1 | Management write strobe |
| mgmt_ps_en | input | 1 | Written power-saving enable |
| mgmt_mode | input | 2 | Written mode: 0 normal, 1 IEEE power down, 2 active sleep, 3 passive sleep |
| mgmt_clk_off | input | 1 | Written clock-stop request |
| link_energy | input | 1 | Energy detector reports a link partner |
| st_ps_en | output | 1 | Current enable |
| st_mode | output | 2 | Current mode field |
| st_clk_off | output | 1 | Current clock-stop request |
| st_wake | output | 1 | Sticky automatic-wake flag |
| pwr_mgmt | output | 1 | Management domain power enable |
| pwr_edet | output | 1 | Energy detector power enable |
| pwr_dp | output | 1 | Datapath power enable |
| clk_run | output | 1 | Internal clock enable |
| nlp_req | output | 1 | One-cycle NLP transmit request |

## Verification
The hardest case to reach is a wake event that lands in the same cycle as a management write. Only one clock edge shows the priority between the two. The bench places the write strobe and link_energy on the same falling edge, so both are sampled together, and then reads the mode and wake flag back. The NLP cadence is the other difficult case. The bench uses a short prescaler and logs every pulse position across three periods. This catches both the offset of the first pulse and any drift in the spacing.

// File: rtl/phy_pwr_pkg.sv
package phy_pwr_pkg;
  typedef enum logic [1:0] {
    PM_RUN       = 2'd0,
    PM_IEEE_PD   = 2'd1,
    PM_SLEEP_ACT = 2'd2,
    PM_SLEEP_PAS = 2'd3
  } pm_mode_t;
endpackage

// File: rtl/phy_pwr_regs.sv
module phy_pwr_regs
  import phy_pwr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic       wr_ps_en,
  input  logic [1:0] wr_mode,
  input  logic       wr_clk_off,
  input  logic       wake_req,
  output logic       ps_en,
  output pm_mode_t   mode,
  output logic       clk_off,
  output logic       wake
);
  logic     ps_en_n, clk_off_n, wake_n;
  pm_mode_t mode_n;

  always_comb begin
    ps_en_n   = ps_en;
    mode_n    = mode;
    clk_off_n = clk_off;
    wake_n    = wake;
    if (we) begin
      ps_en_n   = wr_ps_en;
      mode_n    = pm_mode_t'(wr_mode);
      clk_off_n = wr_clk_off;
      wake_n    = 1'b0;
    end else if (wake_req) begin
      mode_n = PM_RUN;
      wake_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ps_en   <= 1'b0;
      mode    <= PM_RUN;
      clk_off <= 1'b0;
      wake    <= 1'b0;
    end else begin
      ps_en   <= ps_en_n;
      mode    <= mode_n;
      clk_off <= clk_off_n;
      wake    <= wake_n;
    end
  end
endmodule

// File: rtl/phy_pwr_domains.sv
module phy_pwr_domains
  import phy_pwr_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ps_en,
  input  pm_mode_t mode,
  input  logic     clk_off,
  output logic     pwr_mgmt,
  output logic     pwr_edet,
  output logic     pwr_dp,
  output logic     clk_run,
  output logic     sleeping,
  output logic     nlp_active
);
  pm_mode_t eff;
  logic     was_pd, was_pd_n;

  always_comb begin
    eff        = ps_en ? mode : PM_RUN;
    was_pd_n   = (eff == PM_IEEE_PD);
    pwr_mgmt   = 1'b1;
    pwr_edet   = 1'b1;
    pwr_dp     = 1'b0;
    clk_run    = 1'b1;
    sleeping   = 1'b0;
    nlp_active = 1'b0;
    unique case (eff)
      PM_RUN: begin
        pwr_dp = !was_pd;
      end
      PM_IEEE_PD: begin
        pwr_edet = 1'b0;
        clk_run  = !clk_off;
      end
      PM_SLEEP_ACT: begin
        sleeping   = 1'b1;
        nlp_active = 1'b1;
      end
      PM_SLEEP_PAS: begin
        sleeping = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) was_pd <= 1'b0;
    else        was_pd <= was_pd_n;
  end
endmodule

// File: rtl/phy_pwr_nlp_timer.sv
module phy_pwr_nlp_timer #(
  parameter int PRE_DIV   = 25000,
  parameter int NLP_TICKS = 1400
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic pulse
);
  localparam int PW = $clog2(PRE_DIV + 1);
  localparam int TW = $clog2(NLP_TICKS + 1);
  localparam logic [PW-1:0] PRE_LAST  = PW'(PRE_DIV - 1);
  localparam logic [TW-1:0] TICK_LAST = TW'(NLP_TICKS - 1);

  logic [PW-1:0] pre_q, pre_n;
  logic [TW-1:0] tick_q, tick_n;
  logic          pre_wrap;

  always_comb begin
    pre_wrap = (pre_q == PRE_LAST);
    pulse    = run && pre_wrap && (tick_q == TICK_LAST);
    pre_n    = pre_q;
    tick_n   = tick_q;
    if (!run) begin
      pre_n  = '0;
      tick_n = '0;
    end else if (pre_wrap) begin
      pre_n  = '0;
      tick_n = (tick_q == TICK_LAST) ? '0 : tick_q + 1'b1;
    end else begin
      pre_n = pre_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q  <= '0;
      tick_q <= '0;
    end else begin
      pre_q  <= pre_n;
      tick_q <= tick_n;
    end
  end
endmodule

// File: rtl/phy_pwr_ctrl.sv
module phy_pwr_ctrl
  import phy_pwr_pkg::*;
#(
  parameter int PRE_DIV   = 25000,
  parameter int NLP_TICKS = 1400,
  parameter int SYNC_FF   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mgmt_we,
  input  logic       mgmt_ps_en,
  input  logic [1:0] mgmt_mode,
  input  logic       mgmt_clk_off,
  input  logic       link_energy,
  output logic       st_ps_en,
  output logic [1:0] st_mode,
  output logic       st_clk_off,
  output logic       st_wake,
  output logic       pwr_mgmt,
  output logic       pwr_edet,
  output logic       pwr_dp,
  output logic       clk_run,
  output logic       nlp_req
);
  logic [SYNC_FF-1:0] rst_sync;
  logic               rst_int_n;
  pm_mode_t           mode_q;
  logic               sleeping, nlp_active, wake_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[SYNC_FF-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync[SYNC_FF-1];

  assign wake_req = sleeping && link_energy;

  phy_pwr_regs u_regs (
    .clk(clk), .rst_n(rst_int_n), .we(mgmt_we), .wr_ps_en(mgmt_ps_en),
    .wr_mode(mgmt_mode), .wr_clk_off(mgmt_clk_off), .wake_req(wake_req),
    .ps_en(st_ps_en), .mode(mode_q), .clk_off(st_clk_off), .wake(st_wake)
  );
  assign st_mode = mode_q;

  phy_pwr_domains u_dom (
    .clk(clk), .rst_n(rst_int_n), .ps_en(st_ps_en), .mode(mode_q),
    .clk_off(st_clk_off), .pwr_mgmt(pwr_mgmt), .pwr_edet(pwr_edet),
    .pwr_dp(pwr_dp), .clk_run(clk_run), .sleeping(sleeping),
    .nlp_active(nlp_active)
  );

  phy_pwr_nlp_timer #(.PRE_DIV(PRE_DIV), .NLP_TICKS(NLP_TICKS)) u_nlp (
    .clk(clk), .rst_n(rst_int_n), .run(nlp_active), .pulse(nlp_req)
  );
endmodule

// File: rtl/phy_pwr_ctrl_chk.sv
module phy_pwr_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       mgmt_we,
  input logic       link_energy,
  input logic       st_ps_en,
  input logic [1:0] st_mode,
  input logic       st_clk_off,
  input logic       st_wake,
  input logic       pwr_edet,
  input logic       pwr_dp,
  input logic       clk_run,
  input logic       nlp_req
);
  logic in_pd, in_sleep, in_act, in_run;
  assign in_pd    = st_ps_en && (st_mode == 2'd1);
  assign in_sleep = st_ps_en && st_mode[1];
  assign in_act   = st_ps_en && (st_mode == 2'd2);
  assign in_run   = !st_ps_en || (st_mode == 2'd0);

  assert_pd_domains_R3: assert property (@(posedge clk) disable iff (!rst_n)
    in_pd |-> (!pwr_edet && !pwr_dp));
  assert_clk_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !in_pd |-> clk_run);
  assert_pd_clk_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_pd |-> (clk_run == !st_clk_off));
  assert_sleep_domains_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_sleep |-> (pwr_edet && !pwr_dp && clk_run));
  assert_nlp_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nlp_req |-> in_act);
  assert_nlp_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    nlp_req |=> !nlp_req);
  assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sleep && link_energy && !mgmt_we) |=> (st_wake && st_mode == 2'd0 && st_ps_en));
  assert_wake_clr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_we |=> !st_wake);
  assert_pd_exit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    in_pd |=> (!in_run || !pwr_dp));
endmodule

bind phy_pwr_ctrl phy_pwr_ctrl_chk u_chk (.*);

// File: tb/phy_pwr_ctrl_tb.sv
module phy_pwr_ctrl_tb;
  localparam int PRE = 4;
  localparam int TICKS = 5;
  localparam int PERIOD = PRE * TICKS;

  logic clk, rst_n, mgmt_we, mgmt_ps_en, mgmt_clk_off, link_energy;
  logic [1:0] mgmt_mode;
  logic st_ps_en, st_clk_off, st_wake, pwr_mgmt, pwr_edet, pwr_dp, clk_run, nlp_req;
  logic [1:0] st_mode;
  int total, bad;
  bit done;

  phy_pwr_ctrl #(.PRE_DIV(PRE), .NLP_TICKS(TICKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .mgmt_we(mgmt_we), .mgmt_ps_en(mgmt_ps_en),
    .mgmt_mode(mgmt_mode), .mgmt_clk_off(mgmt_clk_off), .link_energy(link_energy),
    .st_ps_en(st_ps_en), .st_mode(st_mode), .st_clk_off(st_clk_off),
    .st_wake(st_wake), .pwr_mgmt(pwr_mgmt), .pwr_edet(pwr_edet), .pwr_dp(pwr_dp),
    .clk_run(clk_run), .nlp_req(nlp_req)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // domain vector {mgmt, edet, dp, clk}
  function automatic int dom();
    return {28'd0, pwr_mgmt, pwr_edet, pwr_dp, clk_run};
  endfunction

  task automatic cfg(bit en, bit [1:0] md, bit off);
    @(negedge clk);
    mgmt_we = 1; mgmt_ps_en = en; mgmt_mode = md; mgmt_clk_off = off;
    @(negedge clk);
    mgmt_we = 0;
  endtask

  task automatic t_reset();
    check("R1 mode", st_mode, 0);
    check("R1 en/off/wake", {st_ps_en, st_clk_off, st_wake}, 0);
    check("R1 domains", dom(), 4'b1111);
    check("R1 nlp", nlp_req, 0);
  endtask

  task automatic t_disabled();
    cfg(0, 2'd1, 1);
    check("R2 domains", dom(), 4'b1111);
    cfg(0, 2'd2, 0);
    for (int i = 0; i < 2 * PERIOD; i++) begin
      if (nlp_req) check("R2 nlp", 1, 0);
      @(negedge clk);
    end
    check("R2 domains sleep-code", dom(), 4'b1111);
  endtask

  task automatic t_pd();
    cfg(1, 2'd1, 0);
    check("R3 pd clock on", dom(), 4'b1001);
    cfg(1, 2'd1, 1);
    check("R3 R4 pd clock off", dom(), 4'b1000);
    // R9 exit to normal
    cfg(1, 2'd0, 1);
    check("R9 exit first cycle", dom(), 4'b1101);
    check("R4 normal ignores clk_off", clk_run, 1);
    @(negedge clk);
    check("R9 exit second cycle", dom(), 4'b1111);
  endtask

  task automatic t_sleep_domains();
    cfg(1, 2'd3, 1);
    check("R5 R4 passive", dom(), 4'b1101);
    for (int i = 0; i < 2 * PERIOD; i++) begin
      if (nlp_req) check("R6 passive nlp", 1, 0);
      @(negedge clk);
    end
    cfg(1, 2'd2, 1);
    check("R5 active", dom(), 4'b1101);
  endtask

  task automatic t_nlp();
    int cnt = 0;
    cfg(1, 2'd0, 0);
    @(negedge clk);
    @(negedge clk);
    mgmt_we = 1; mgmt_ps_en = 1; mgmt_mode = 2'd2; mgmt_clk_off = 0;
    @(negedge clk);
    mgmt_we = 0;
    for (int i = 0; i < 3 * PERIOD; i++) begin
      bit exp = ((i % PERIOD) == PERIOD - 1);
      if (nlp_req !== exp) check($sformatf("R6 nlp idx %0d", i), nlp_req, exp);
      if (nlp_req) cnt++;
      @(negedge clk);
    end
    check("R6 pulse count", cnt, 3);
  endtask

  task automatic t_wake();
    cfg(1, 2'd3, 0);
    link_energy = 1;
    @(negedge clk);
    link_energy = 0;
    check("R7 mode cleared", st_mode, 0);
    check("R7 en kept, wake set", {st_ps_en, st_wake}, 2'b11);
    check("R7 full power", dom(), 4'b1111);
    repeat (3) @(negedge clk);
    check("R8 wake sticky", st_wake, 1);
    cfg(1, 2'd1, 0);
    check("R8 write clears wake", st_wake, 0);
    link_energy = 1;
    @(negedge clk);
    @(negedge clk);
    link_energy = 0;
    check("R8 pd ignores energy", {st_mode, st_wake}, 3'b010);
    cfg(1, 2'd0, 0);
    link_energy = 1;
    @(negedge clk);
    link_energy = 0;
    check("R8 normal ignores energy", st_wake, 0);
  endtask

  task automatic t_collide();
    cfg(1, 2'd2, 0);
    @(negedge clk);
    mgmt_we = 1; mgmt_ps_en = 1; mgmt_mode = 2'd3; mgmt_clk_off = 0;
    link_energy = 1;
    @(negedge clk);
    mgmt_we = 0; link_energy = 0;
    check("R10 write wins mode", st_mode, 3);
    check("R10 wake stays clear", st_wake, 0);
  endtask

  initial begin
    total = 0; bad = 0; done = 0;
    rst_n = 0; mgmt_we = 0; mgmt_ps_en = 0; mgmt_mode = 0;
    mgmt_clk_off = 0; link_energy = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_disabled();
    t_pd();
    t_sleep_domains();
    t_nlp();
    t_wake();
    t_collide();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule